// File: doc/BRIEF.md
# NAND Flash Command Interface with Area Pointer

This block is the device-side front end of a small-page NAND flash model. It watches the chip-enable, command-latch, address-latch, write-strobe and read-strobe pins and an 8-bit I/O bus, all sampled on a system clock. From these it decodes command bytes, address bytes and data bytes. It runs read, page-program, block-erase, identifier-read, status-read and reset sequences against a small internal byte array. A page is 528 bytes: 512 main bytes followed by 16 spare bytes. The array keeps `NPAGE` pages, selected by the low bits of the first row byte. Higher row bits alias onto the same pages.

An area pointer chooses where a read or program begins. It can point at the first half of the main area, the second half, or the spare area. Command 01h selects the second half for one operation only. Commands 00h and 50h set the first half and the spare area, and that choice lasts until another pointer command arrives.

Each array operation holds ready/busy low for a modelled number of clock cycles. Status bit 6 follows ready/busy. Bit 7 reports the write-protect pin. Bit 0 flags a program or erase that was refused. The strobe interface has no handshake: the host paces every byte with its own strobes and polls ready/busy or the status byte. Array contents are undefined until the first erase.

Top module: `nand_cmd_if`

## Requirements
- R1: A command byte is taken only on a write-strobe rising edge while chip-enable is low, CLE is high and ALE is low. A strobe edge while chip-enable is high has no effect.
- R2: An address byte is taken on a write-strobe rising edge while ALE is high and CLE is low. A read takes one column byte and then three row bytes. Ready/busy goes low on the edge of the fourth byte, and data appears once it returns high. `io_oe` is high exactly while chip-enable and the read strobe are low and CLE and ALE are low.
- R3: After 00h, the column byte addresses bytes 0..255 of the page, and this pointer persists across operations.
- R4: After 01h, the column byte addresses from byte 256 onward. This applies to one read or program only: once that operation has taken its address bytes, the pointer returns to the first half.
- R5: After 50h, the start column is 512 plus the low four bits of the column byte. The upper four bits are ignored. The pointer persists until another pointer command arrives.
- R6: 80h, four address bytes, data bytes, then 10h programs the page. Each data byte is ANDed into the cell at the running column. Ready/busy is then low for `PROG_CYC` cycles.
- R7: 60h, three row bytes, then D0h sets every byte of the model array to FFh. Ready/busy is low for `NPAGE`*528 cycles.
- R8: After 70h, read cycles return {write-protect pin, ready, five zero bits, error}. 70h is also accepted while busy.
- R9: Ready/busy is low for exactly the length of the running operation. After a read address sequence that length is `READ_CYC` cycles.
- R10: A 10h or D0h confirm while write-protect is low starts no operation, leaves the array unchanged and sets status bit 0. A confirm that is accepted clears bit 0.
- R11: FFh, accepted at any time, ends a busy interval on the next edge, clears status bit 0, returns the pointer to the first half and abandons any partly entered sequence.
- R12: 90h followed by one address byte makes read cycles return `ID0`, then `ID1`, then 00h.
- R13: Commands out of sequence are ignored. This covers 10h outside a program load, D0h before three erase address bytes, and any command other than 70h and FFh while busy.
- R14: The column stops at 528. Reads there return FFh and data bytes there are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every strobe |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write strobe; bytes are taken on its rising edge |
| re_n | input | 1 | Read strobe; the column advances on its rising edge |
| wp_n | input | 1 | Write protect, active low |
| io_in | input | 8 | Command, address and data byte from the host |
| io_out | output | 8 | Array, status or identifier byte |
| io_oe | output | 1 | High while the block drives the bus |
| rb | output | 1 | Ready (1) or busy (0) |

## Verification
A strobe rising edge is seen on the first clock edge that samples the pin high. Its effect (ready/busy falling, the pointer changing, the column moving) is visible from that edge on. The bench therefore drives pins 2 ns after a rising edge and reads results at the following falling edge. A busy interval of L cycles that starts on edge k ends on edge k+L. The behavioural model counts the same L and compares ready/busy on every falling edge. During every read strobe it also compares the output byte against the model: status bytes always, array and identifier bytes only while ready.

// File: rtl/nand_ci_pkg.sv
`timescale 1ns/1ps
package nand_ci_pkg;
  typedef enum logic [1:0] {AREA_A, AREA_B, AREA_C} area_t;
  typedef enum logic [2:0] {ST_IDLE, ST_RADDR, ST_PADDR, ST_PDATA, ST_EADDR, ST_IADDR} st_t;
  typedef enum logic [1:0] {SEL_ARR, SEL_STAT, SEL_ID} sel_t;
  typedef enum logic [1:0] {OP_READ, OP_PROG, OP_ERASE} op_t;

  localparam logic [7:0] C_RDA   = 8'h00;
  localparam logic [7:0] C_RDB   = 8'h01;
  localparam logic [7:0] C_RDC   = 8'h50;
  localparam logic [7:0] C_PROG  = 8'h80;
  localparam logic [7:0] C_PCONF = 8'h10;
  localparam logic [7:0] C_ERASE = 8'h60;
  localparam logic [7:0] C_ECONF = 8'hD0;
  localparam logic [7:0] C_STAT  = 8'h70;
  localparam logic [7:0] C_ID    = 8'h90;
  localparam logic [7:0] C_RST   = 8'hFF;
endpackage

// File: rtl/nand_strobe_sync.sv
`timescale 1ns/1ps
module nand_strobe_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic cle,
  input  logic ale,
  input  logic we_n,
  input  logic re_n,
  output logic cmd_stb,
  output logic addr_stb,
  output logic data_stb,
  output logic rd_adv
);
  logic we_d, re_d, we_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_d <= 1'b1;
      re_d <= 1'b1;
    end else begin
      we_d <= we_n;
      re_d <= re_n;
    end
  end

  assign we_rise  = !we_d && we_n && !ce_n;
  assign cmd_stb  = we_rise && cle && !ale;
  assign addr_stb = we_rise && ale && !cle;
  assign data_stb = we_rise && !ale && !cle;
  assign rd_adv   = !re_d && re_n && !ce_n;
endmodule

// File: rtl/nand_area_ptr.sv
`timescale 1ns/1ps
module nand_area_ptr
  import nand_ci_pkg::*;
#(
  parameter int MAIN = 512,
  parameter int COLW = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_a,
  input  logic            set_b,
  input  logic            set_c,
  input  logic            clr,
  input  logic            consume,
  input  logic [7:0]      col_byte,
  output area_t           area_o,
  output logic [COLW-1:0] start_col
);
  localparam int HALF = MAIN / 2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          area_o <= AREA_A;
    else if (clr || set_a)               area_o <= AREA_A;
    else if (set_b)                      area_o <= AREA_B;
    else if (set_c)                      area_o <= AREA_C;
    else if (consume && area_o == AREA_B) area_o <= AREA_A;
  end

  always_comb begin
    case (area_o)
      AREA_B:  start_col = COLW'(HALF) + COLW'(col_byte);
      AREA_C:  start_col = COLW'(MAIN) + COLW'(col_byte[3:0]);
      default: start_col = COLW'(col_byte);
    endcase
  end

  // R4
  oneshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    consume && !set_b && !set_c && !clr |=> area_o != AREA_B);
  // R5
  spare_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    area_o == AREA_C && !set_a && !set_b && !clr |=> area_o == AREA_C);
endmodule

// File: rtl/nand_busy_timer.sv
`timescale 1ns/1ps
module nand_busy_timer #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic [CW-1:0] len,
  output logic          busy_o,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      cnt_o  <= '0;
      lim    <= '0;
    end else if (abort) begin
      busy_o <= 1'b0;
    end else if (start) begin
      busy_o <= 1'b1;
      cnt_o  <= '0;
      lim    <= len;
    end else if (busy_o) begin
      if (cnt_o == lim - 1'b1) busy_o <= 1'b0;
      else                     cnt_o  <= cnt_o + 1'b1;
    end
  end

  // R9
  busy_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start));
endmodule

// File: rtl/nand_cmd_if.sv
`timescale 1ns/1ps
module nand_cmd_if
  import nand_ci_pkg::*;
#(
  parameter int NPAGE    = 4,
  parameter int MAIN     = 512,
  parameter int SPARE    = 16,
  parameter int READ_CYC = 8,
  parameter int PROG_CYC = 24,
  parameter logic [7:0] ID0 = 8'hC3,
  parameter logic [7:0] ID1 = 8'h5A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       we_n,
  input  logic       re_n,
  input  logic       wp_n,
  input  logic [7:0] io_in,
  output logic [7:0] io_out,
  output logic       io_oe,
  output logic       rb
);
  localparam int PAGE_B = MAIN + SPARE;
  localparam int PAW    = $clog2(NPAGE);
  localparam int DEPTH  = NPAGE * PAGE_B;
  localparam int AW     = $clog2(DEPTH);
  localparam int COLW   = $clog2(PAGE_B + 1);
  localparam int LMAX   = (DEPTH > PROG_CYC) ? ((DEPTH > READ_CYC) ? DEPTH : READ_CYC)
                                             : ((PROG_CYC > READ_CYC) ? PROG_CYC : READ_CYC);
  localparam int CW     = $clog2(LMAX + 1);

  logic cmd_stb, addr_stb, data_stb, rd_adv;
  logic busy;
  logic [CW-1:0] cnt, len;
  area_t area;
  logic [COLW-1:0] start_col, col;
  st_t  st;
  sel_t sel;
  op_t  op;
  logic [1:0] acnt, idx;
  logic [PAW-1:0] page;
  logic [7:0] col_byte;
  logic err;
  logic [7:0] mem [DEPTH];

  nand_strobe_sync u_sync (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
    .cmd_stb(cmd_stb), .addr_stb(addr_stb), .data_stb(data_stb), .rd_adv(rd_adv));

  logic is_rst, live_cmd, addr_last, rd_go, pa_done, prog_cmd, ers_cmd, start, pg_wr;
  assign is_rst    = cmd_stb && io_in == C_RST;
  assign live_cmd  = cmd_stb && !busy;
  assign addr_last = addr_stb && !busy && acnt == 2'd3;
  assign rd_go     = addr_last && st == ST_RADDR;
  assign pa_done   = addr_last && st == ST_PADDR;
  assign prog_cmd  = live_cmd && io_in == C_PCONF && st == ST_PDATA;
  assign ers_cmd   = live_cmd && io_in == C_ECONF && st == ST_EADDR && acnt == 2'd3;
  assign start     = rd_go || ((prog_cmd || ers_cmd) && wp_n);
  assign len       = rd_go ? CW'(READ_CYC) : prog_cmd ? CW'(PROG_CYC) : CW'(DEPTH);
  assign pg_wr     = data_stb && st == ST_PDATA && wp_n && col < COLW'(PAGE_B);

  nand_area_ptr #(.MAIN(MAIN), .COLW(COLW)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .set_a(live_cmd && io_in == C_RDA), .set_b(live_cmd && io_in == C_RDB),
    .set_c(live_cmd && io_in == C_RDC), .clr(is_rst), .consume(rd_go || pa_done),
    .col_byte(col_byte), .area_o(area), .start_col(start_col));

  nand_busy_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(is_rst), .len(len),
    .busy_o(busy), .cnt_o(cnt));

  logic [AW-1:0] waddr, raddr;
  logic [COLW-1:0] rcol;
  assign rcol  = (col < COLW'(PAGE_B)) ? col : '0;
  assign waddr = AW'(page) * AW'(PAGE_B) + AW'(col);
  assign raddr = AW'(page) * AW'(PAGE_B) + AW'(rcol);

  always_ff @(posedge clk) begin
    if (busy && op == OP_ERASE) mem[AW'(cnt)] <= 8'hFF;
    else if (pg_wr)             mem[waddr]    <= mem[waddr] & io_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; sel <= SEL_ARR; op <= OP_READ; acnt <= '0; idx <= '0;
      col <= '0; page <= '0; col_byte <= '0; err <= 1'b0;
    end else if (cmd_stb) begin
      if (is_rst) begin
        st <= ST_IDLE; err <= 1'b0; sel <= SEL_ARR; acnt <= '0;
      end else if (io_in == C_STAT) begin
        sel <= SEL_STAT;
      end else if (!busy) begin
        case (io_in)
          C_RDA, C_RDB, C_RDC: begin st <= ST_RADDR; acnt <= '0; sel <= SEL_ARR; end
          C_PROG:  begin st <= ST_PADDR; acnt <= '0; end
          C_ERASE: begin st <= ST_EADDR; acnt <= '0; end
          C_ID:    st <= ST_IADDR;
          C_PCONF: if (st == ST_PDATA) begin
                     st <= ST_IDLE; err <= !wp_n; op <= OP_PROG;
                   end
          C_ECONF: if (st == ST_EADDR && acnt == 2'd3) begin
                     st <= ST_IDLE; err <= !wp_n; op <= OP_ERASE;
                   end
          default: ;
        endcase
      end
    end else if (addr_stb && !busy) begin
      case (st)
        ST_RADDR, ST_PADDR: begin
          if (acnt == 2'd0) col_byte <= io_in;
          if (acnt == 2'd1) page <= io_in[PAW-1:0];
          if (acnt == 2'd3) begin
            col <= start_col;
            if (st == ST_RADDR) begin st <= ST_IDLE; op <= OP_READ; end
            else st <= ST_PDATA;
          end
          acnt <= acnt + 2'd1;
        end
        ST_EADDR: if (acnt != 2'd3) acnt <= acnt + 2'd1;
        ST_IADDR: begin st <= ST_IDLE; sel <= SEL_ID; idx <= '0; end
        default: ;
      endcase
    end else if (data_stb && st == ST_PDATA) begin
      if (col < COLW'(PAGE_B)) col <= col + 1'b1;
    end else if (rd_adv && !busy) begin
      if (sel == SEL_ARR && col < COLW'(PAGE_B)) col <= col + 1'b1;
      if (sel == SEL_ID && idx != 2'd2) idx <= idx + 2'd1;
    end
  end

  always_comb begin
    case (sel)
      SEL_STAT: io_out = {wp_n, !busy, 5'b0, err};
      SEL_ID:   io_out = (idx == 2'd0) ? ID0 : (idx == 2'd1) ? ID1 : 8'h00;
      default:  io_out = (col < COLW'(PAGE_B)) ? mem[raddr] : 8'hFF;
    endcase
  end
  assign io_oe = !ce_n && !re_n && !cle && !ale;
  assign rb    = !busy;

  // R10
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb && io_in == C_PCONF && st == ST_PDATA && !busy && !wp_n |=> !busy && err);
  // R14
  col_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col <= COLW'(PAGE_B));
  // R13
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_stb && io_in == C_RDC |=> $stable(area));
endmodule

// File: tb/sim_nand_cmd_if.sv
`timescale 1ns/1ps
module sim_nand_cmd_if;
  localparam int NPAGE = 4, PB = 528, DEPTH = NPAGE * PB, RDC = 8, PGC = 24;
  localparam logic [7:0] I0 = 8'hC3, I1 = 8'h5A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b0, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
  logic [7:0] io_in = 8'h00;
  logic [7:0] io_out;
  logic io_oe, rb;

  always #4 clk = ~clk;

  nand_cmd_if #(.NPAGE(NPAGE), .MAIN(512), .SPARE(16), .READ_CYC(RDC), .PROG_CYC(PGC),
                .ID0(I0), .ID1(I1)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
    .wp_n(wp_n), .io_in(io_in), .io_out(io_out), .io_oe(io_oe), .rb(rb));

  int checks = 0, errs = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [7:0] mm [DEPTH];
  int m_busy, m_phase, m_acnt, m_col, m_page, m_colb, m_idx;
  int m_area;   // 0 first half, 1 second half one-shot, 2 spare
  int m_out;    // 0 array, 1 status, 2 id
  bit m_err, we_p, re_p;

  function automatic logic [7:0] model_byte();
    if (m_out == 1) return {wp_n, m_busy == 0, 5'b0, m_err};
    if (m_out == 2) return (m_idx == 0) ? I0 : (m_idx == 1) ? I1 : 8'h00;
    return (m_col < PB) ? mm[m_page * PB + m_col] : 8'hFF;
  endfunction

  task automatic m_cmd(input logic [7:0] b, input bit wb);
    if (b == 8'hFF) begin
      m_phase = 0; m_err = 0; m_out = 0; m_acnt = 0; m_area = 0; m_busy = 0;
    end else if (b == 8'h70) m_out = 1;
    else if (!wb) begin
      case (b)
        8'h00, 8'h01, 8'h50: begin
          m_area = (b == 8'h00) ? 0 : (b == 8'h01) ? 1 : 2;
          m_phase = 1; m_acnt = 0; m_out = 0;
        end
        8'h80: begin m_phase = 2; m_acnt = 0; end
        8'h60: begin m_phase = 4; m_acnt = 0; end
        8'h90: m_phase = 5;
        8'h10: if (m_phase == 3) begin
          m_phase = 0; m_err = !wp_n;
          if (wp_n) m_busy = PGC;
        end
        8'hD0: if (m_phase == 4 && m_acnt == 3) begin
          m_phase = 0; m_err = !wp_n;
          if (wp_n) begin
            m_busy = DEPTH;
            for (int i = 0; i < DEPTH; i++) mm[i] = 8'hFF;
          end
        end
        default: ;
      endcase
    end
  endtask

  task automatic m_addr(input logic [7:0] b, input bit wb);
    if (wb) return;
    if (m_phase == 1 || m_phase == 2) begin
      if (m_acnt == 0) m_colb = b;
      if (m_acnt == 1) m_page = b % NPAGE;
      m_acnt++;
      if (m_acnt == 4) begin
        m_col = (m_area == 0) ? m_colb : (m_area == 1) ? 256 + m_colb : 512 + (m_colb % 16);
        if (m_area == 1) m_area = 0;
        if (m_phase == 1) begin m_phase = 0; m_busy = RDC; end
        else m_phase = 3;
      end
    end else if (m_phase == 4) begin
      if (m_acnt < 3) m_acnt++;
    end else if (m_phase == 5) begin
      m_phase = 0; m_out = 2; m_idx = 0;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_phase = 0; m_acnt = 0; m_col = 0; m_page = 0; m_colb = 0; m_idx = 0;
      m_area = 0; m_out = 0; m_err = 0; we_p = 1; re_p = 1;
    end else begin
      bit wb, wr, rr;
      wb = m_busy > 0;
      if (m_busy > 0) m_busy--;
      wr = !we_p && we_n && !ce_n;
      rr = !re_p && re_n && !ce_n;
      if (wr && cle && !ale) m_cmd(io_in, wb);
      else if (wr && ale && !cle) m_addr(io_in, wb);
      else if (wr && !ale && !cle) begin
        if (m_phase == 3 && m_col < PB) begin
          if (wp_n) mm[m_page * PB + m_col] = mm[m_page * PB + m_col] & io_in;
          m_col++;
        end
      end else if (rr && !wb) begin
        if (m_out == 0 && m_col < PB) m_col++;
        if (m_out == 2 && m_idx < 2) m_idx++;
      end
      we_p = we_n; re_p = re_n;
    end
  end

  // per-cycle comparison on the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic eo;
      chk(rb === (m_busy == 0), "R9 ready/busy", {7'b0, rb}, {7'b0, m_busy == 0});
      eo = !ce_n && !re_n && !cle && !ale;
      chk(io_oe === eo, "R2 io_oe", {7'b0, io_oe}, {7'b0, eo});
      if (eo && (m_out == 1 || m_busy == 0))
        chk(io_out === model_byte(), (m_out == 1) ? "R8 status" : (m_out == 2) ? "R12 id" : "R2 data",
            io_out, model_byte());
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic cmd(input logic [7:0] b, input bit ce_hi = 0);
    ce_n = ce_hi; cle = 1; ale = 0; io_in = b; we_n = 0; tick();
    we_n = 1; tick();
    cle = 0; ce_n = 0;
  endtask

  task automatic adr(input logic [7:0] b);
    ale = 1; cle = 0; io_in = b; we_n = 0; tick();
    we_n = 1; tick();
    ale = 0;
  endtask

  task automatic addr4(input logic [7:0] c, input logic [7:0] p);
    adr(c); adr(p); adr(8'h00); adr(8'h00);
  endtask

  task automatic wr(input logic [7:0] b);
    io_in = b; we_n = 0; tick();
    we_n = 1; tick();
  endtask

  task automatic rdx(input logic [7:0] exp, input string tag);
    logic [7:0] v;
    re_n = 0;
    @(negedge clk); #1 v = io_out;
    chk(v === exp, tag, v, exp);
    @(posedge clk); #2 re_n = 1; tick();
  endtask

  task automatic wait_ready();
    int n = 0;
    while (rb !== 1'b1 && n < 5000) begin tick(); n++; end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    tick(); tick();
    rst_n = 1; tick();
    chk(rb === 1'b1, "R9 reset ready", {7'b0, rb}, 8'h01);
    cmd(8'h70);
    rdx(8'hC0, "R8 status idle");

    // R7 erase with status poll during busy
    cmd(8'h60); adr(8'h00); adr(8'h00); adr(8'h00); cmd(8'hD0);
    chk(rb === 1'b0, "R7 erase busy", {7'b0, rb}, 8'h00);
    cmd(8'h70);
    rdx(8'h80, "R8 status busy");
    wait_ready();

    // R6 program page 1 from column 5, then R3 read back
    cmd(8'h80); addr4(8'd5, 8'd1);
    for (int i = 0; i < 8; i++) wr(8'h10 + 8'(i));
    cmd(8'h10);
    chk(rb === 1'b0, "R6 program busy", {7'b0, rb}, 8'h00);
    wait_ready();
    cmd(8'h00); addr4(8'd5, 8'd1);
    chk(rb === 1'b0, "R2 read busy", {7'b0, rb}, 8'h00);
    wait_ready();
    for (int i = 0; i < 8; i++) rdx(8'h10 + 8'(i), "R3 first half");

    // R6 AND into programmed cell
    cmd(8'h80); addr4(8'd5, 8'd1); wr(8'h0F); cmd(8'h10); wait_ready();
    cmd(8'h00); addr4(8'd5, 8'd1); wait_ready();
    rdx(8'h00, "R6 and");
    rdx(8'h11, "R6 neighbour");

    // R1 command with chip enable high is ignored
    cmd(8'h70, 1);
    rdx(8'h12, "R1 ce high");

    // R4 second-half one-shot
    cmd(8'h01); cmd(8'h80); addr4(8'd3, 8'd1);
    for (int i = 0; i < 4; i++) wr(8'hA0 + 8'(i));
    cmd(8'h10); wait_ready();
    cmd(8'h80); addr4(8'd7, 8'd2); wr(8'h3C); cmd(8'h10); wait_ready();
    cmd(8'h00); addr4(8'd7, 8'd2); wait_ready();
    rdx(8'h3C, "R4 reverted");
    cmd(8'h01); addr4(8'd3, 8'd1); wait_ready();
    for (int i = 0; i < 4; i++) rdx(8'hA0 + 8'(i), "R4 second half");

    // R5 spare pointer, upper column bits ignored, persistence
    cmd(8'h50); cmd(8'h80); addr4(8'hF1, 8'd1); wr(8'h5A); wr(8'h6B); cmd(8'h10); wait_ready();
    cmd(8'h50); addr4(8'h01, 8'd1); wait_ready();
    rdx(8'h5A, "R5 spare"); rdx(8'h6B, "R5 spare");
    cmd(8'h80); addr4(8'h02, 8'd3); wr(8'h77); cmd(8'h10); wait_ready();
    cmd(8'h50); addr4(8'h02, 8'd3); wait_ready();
    rdx(8'h77, "R5 persist");

    // R14 end of page
    cmd(8'h80); addr4(8'h0E, 8'd1); wr(8'h11); wr(8'h22); wr(8'h33); cmd(8'h10); wait_ready();
    cmd(8'h50); addr4(8'h0E, 8'd1); wait_ready();
    rdx(8'h11, "R14 byte 526"); rdx(8'h22, "R14 byte 527");
    rdx(8'hFF, "R14 past end"); rdx(8'hFF, "R14 past end");

    // R12 identifier
    cmd(8'h90); adr(8'h00);
    rdx(I0, "R12 id0"); rdx(I1, "R12 id1"); rdx(8'h00, "R12 tail");

    // R10 write protect
    wp_n = 0;
    cmd(8'h00); cmd(8'h80); addr4(8'd0, 8'd0); wr(8'hAA); cmd(8'h10);
    chk(rb === 1'b1, "R10 no busy", {7'b0, rb}, 8'h01);
    cmd(8'h70); rdx(8'h41, "R10 status");
    wp_n = 1;
    cmd(8'h00); addr4(8'd0, 8'd0); wait_ready();
    rdx(8'hFF, "R10 unchanged");
    cmd(8'h80); addr4(8'd1, 8'd0); wr(8'h55); cmd(8'h10); wait_ready();
    cmd(8'h70); rdx(8'hC0, "R10 cleared");

    // R11 abort and reset
    cmd(8'h60); adr(8'h00); adr(8'h00); adr(8'h00); cmd(8'hD0);
    tick(); tick();
    cmd(8'hFF);
    chk(rb === 1'b1, "R11 abort", {7'b0, rb}, 8'h01);
    cmd(8'h60); adr(8'h00); adr(8'h00); adr(8'h00); cmd(8'hD0); wait_ready();
    wp_n = 0; cmd(8'h80); addr4(8'd0, 8'd0); cmd(8'h10); wp_n = 1;
    cmd(8'h50); cmd(8'hFF);
    cmd(8'h70); rdx(8'hC0, "R11 status");
    cmd(8'h80); addr4(8'd4, 8'd0); wr(8'h5E); cmd(8'h10); wait_ready();
    cmd(8'h00); addr4(8'd4, 8'd0); wait_ready();
    rdx(8'h5E, "R11 pointer");

    // R13 out-of-sequence commands
    cmd(8'h10);
    chk(rb === 1'b1, "R13 stray confirm", {7'b0, rb}, 8'h01);
    cmd(8'h60); adr(8'h00); adr(8'h00); cmd(8'hD0);
    chk(rb === 1'b1, "R13 early erase confirm", {7'b0, rb}, 8'h01);
    cmd(8'hFF);
    cmd(8'h00); addr4(8'd4, 8'd0);
    cmd(8'h50);
    wait_ready();
    rdx(8'h5E, "R13 busy ignored");
    cmd(8'h80); addr4(8'd9, 8'd0); wr(8'h42); cmd(8'h10); wait_ready();
    cmd(8'h00); addr4(8'd9, 8'd0); wait_ready();
    rdx(8'h42, "R13 pointer kept");

    tick(); tick();
    finish_run();
  end
endmodule